// File: doc/BRIEF.md
# Multiplierless Constant-Coefficient FIR Filter

This block is a fully pipelined finite impulse response filter with fixed integer coefficients. It takes one signed sample per clock with a valid flag and returns a signed full-precision result with its own valid flag. No multiplier is built anywhere. Each coefficient is recoded at elaboration into signed binary digits, with no two adjacent digits nonzero, and its product with the current sample is formed from shifted copies of the sample that are added or subtracted.

Coefficients whose magnitudes share the same odd factor share one shift-add tree. Only the distinct odd factors get adder trees, and every other tap takes a shifted and possibly negated copy of the shared result. The products of the current sample feed a transposed chain of registered adders, so the longest path holds adders only.

The filter advances only on valid samples. Cycles without a valid sample leave the history and the output alone, so gaps in the input stream are transparent to the convolution.

Top module: `shiftadd_fir`

## Requirements
- R1: For the valid input samples x[0], x[1], ..., output result number n equals the sum over k = 0..NTAPS-1 of C[k]·x[n−k], where samples before the first one after reset count as zero. With the default coefficients C = {3, −7, 14, 0, −28, 21, 6, −1} (k = 0 first), IN_W = 12 and ACC_W = 23, the result is exact.
- R2: A single sample of value A followed by zeros produces the outputs A·C[0], A·C[1], ..., A·C[NTAPS−1], in that order.
- R3: Results are exact for every input value, including the extremes −2^(IN_W−1) and 2^(IN_W−1)−1. The output width ACC_W = IN_W + COEF_W + ceil(log2 NTAPS) never wraps.
- R4: Each valid input sampled at a rising edge produces exactly one output with out_valid high, visible after the fourth rising edge counted from the sampling edge. out_valid is never high without a matching input.
- R5: In cycles where in_valid is low, in_x has no effect. y_out holds its last value while out_valid is low, and the history does not advance.
- R6: While rst is high, out_valid and y_out are driven to zero on the next edge and all stored history is cleared.
- R7: Negative coefficients, a zero coefficient, and coefficients that differ only by a power of two and a sign (−7, 14, −28 and 3, 6) each give their exact product.
- R8: A new sample is accepted on every clock when in_valid stays high, with one result per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_x carries a sample this cycle |
| in_x | input | IN_W | Signed input sample |
| out_valid | output | 1 | y_out carries a new result this cycle |
| y_out | output | ACC_W | Signed full-precision filter result |

## Verification
An impulse shows each tap's coefficient on its own, in order, which separates errors in the digit recoding of one tap or in its sharing from errors in chain order. A step and long runs of the extreme input values exercise the accumulated sum and the output width. Random streams, both back-to-back and with random idle cycles, are compared against a convolution model; they separate an error in the summation from an error in gating the history on the valid flag. A reset in the middle of the stream, followed by an impulse, shows that no old history leaks into new results.

// File: rtl/sa_fir_pkg.sv
package sa_fir_pkg;

  // Signed digit at position pos of the non-adjacent recoding of c.
  function automatic int naf_digit(input int c, input int pos);
    int v;
    int d;
    v = c;
    d = 0;
    for (int i = 0; i <= pos; i++) begin
      if ((v & 1) != 0) begin
        d = ((v & 3) == 1) ? 1 : -1;
        v = v - d;
      end else begin
        d = 0;
      end
      v = v >>> 1;
    end
    return d;
  endfunction

  function automatic int abs_i(input int c);
    return (c < 0) ? -c : c;
  endfunction

  // Power-of-two exponent removed from |c| (zero for c == 0).
  function automatic int pow2_shift(input int c);
    int v;
    int s;
    v = abs_i(c);
    s = 0;
    if (v != 0) begin
      while ((v & 1) == 0) begin
        v = v >> 1;
        s++;
      end
    end
    return s;
  endfunction

  // Odd factor of |c|; shared adder trees are keyed by this value.
  function automatic int odd_factor(input int c);
    return abs_i(c) >> pow2_shift(c);
  endfunction

  function automatic int acc_width(input int in_w, input int coef_w, input int ntaps);
    return in_w + coef_w + $clog2(ntaps);
  endfunction

endpackage

// File: rtl/sa_fir_mulblock.sv
module sa_fir_mulblock #(
  parameter int IN_W   = 12,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 8,
  parameter int ACC_W  = 23,
  parameter int TAP_COEF [NTAPS] = '{default: 1}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  output logic                    prod_valid,
  output logic signed [ACC_W-1:0] prod_q [NTAPS]
);
  import sa_fir_pkg::*;

  localparam int NDIG = COEF_W + 1;

  logic                    v_in_q, v_fund_q;
  logic signed [IN_W-1:0]  x_q;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] fund_q [NTAPS];

  assign x_ext = {{(ACC_W-IN_W){x_q[IN_W-1]}}, x_q};

  // Lowest tap whose coefficient has the same odd factor owns the tree.
  function automatic int owner_of(input int k);
    for (int j = 0; j < NTAPS; j++)
      if (odd_factor(TAP_COEF[j]) == odd_factor(TAP_COEF[k])) return j;
    return k;
  endfunction

  // Constant product by shift, add and subtract of the recoded digits.
  function automatic logic signed [ACC_W-1:0] shift_add(input logic signed [ACC_W-1:0] x,
                                                        input int f);
    logic signed [ACC_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NDIG; p++) begin
      if (naf_digit(f, p) == 1)       acc = acc + (x <<< p);
      else if (naf_digit(f, p) == -1) acc = acc - (x <<< p);
    end
    return acc;
  endfunction

  // Stage 1: capture the sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_in_q <= 1'b0;
      x_q    <= '0;
    end else begin
      v_in_q <= in_valid;
      if (in_valid) x_q <= in_x;
    end
  end

  // Stage 2: one adder tree per distinct odd factor.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_fund_q <= 1'b0;
      for (int k = 0; k < NTAPS; k++) fund_q[k] <= '0;
    end else begin
      v_fund_q <= v_in_q;
      for (int k = 0; k < NTAPS; k++) begin
        if (owner_of(k) == k && TAP_COEF[k] != 0)
          fund_q[k] <= shift_add(x_ext, odd_factor(TAP_COEF[k]));
        else
          fund_q[k] <= '0;
      end
    end
  end

  // Stage 3: per-tap scaling and sign of the shared result.
  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam int OWN = owner_of(k);
      localparam int SH  = pow2_shift(TAP_COEF[k]);
      always_ff @(posedge clk) begin
        if (rst)                     prod_q[k] <= '0;
        else if (TAP_COEF[k] == 0)   prod_q[k] <= '0;
        else if (TAP_COEF[k] < 0)    prod_q[k] <= -(fund_q[OWN] <<< SH);
        else                         prod_q[k] <= fund_q[OWN] <<< SH;
      end

      localparam logic signed [ACC_W-1:0] CK = ACC_W'(TAP_COEF[k]);
      // R3, R7: each product equals coefficient times the captured sample.
      a_r3_exact_product: assert property (@(posedge clk) disable iff (rst)
        prod_valid |-> prod_q[k] == CK * $past(x_ext, 2));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prod_valid <= 1'b0;
    else     prod_valid <= v_fund_q;
  end

endmodule

// File: rtl/sa_fir_chain.sv
module sa_fir_chain #(
  parameter int NTAPS = 8,
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prod_valid,
  input  logic signed [ACC_W-1:0] prod_q [NTAPS],
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] y_out
);
  logic signed [ACC_W-1:0] part_q [NTAPS];

  // Transposed form: the highest tap enters at the far end of the chain.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      for (int k = 0; k < NTAPS; k++) part_q[k] <= '0;
    end else begin
      out_valid <= prod_valid;
      if (prod_valid) begin
        part_q[NTAPS-1] <= prod_q[NTAPS-1];
        for (int k = 0; k < NTAPS-1; k++) part_q[k] <= prod_q[k] + part_q[k+1];
      end
    end
  end

  assign y_out = part_q[0];

  // R5: no result cycle leaves the output unchanged.
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |=> $stable(y_out));

endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir #(
  parameter int IN_W   = 12,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 8,
  parameter int TAP_COEF [NTAPS] = '{3, -7, 14, 0, -28, 21, 6, -1},
  parameter int ACC_W  = sa_fir_pkg::acc_width(IN_W, COEF_W, NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_x,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] y_out
);
  localparam int LATENCY = 4;

  logic                    prod_valid;
  logic signed [ACC_W-1:0] prod_q [NTAPS];

  sa_fir_mulblock #(
    .IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .ACC_W(ACC_W), .TAP_COEF(TAP_COEF)
  ) u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .prod_valid(prod_valid), .prod_q(prod_q)
  );

  sa_fir_chain #(
    .NTAPS(NTAPS), .ACC_W(ACC_W)
  ) u_chain (
    .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod_q(prod_q),
    .out_valid(out_valid), .y_out(y_out)
  );

  // Edges since reset release, saturating at the pipeline depth.
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst < 3'(LATENCY)) since_rst <= since_rst + 3'd1;
  end

  // R4: out_valid follows in_valid by the fixed pipeline depth.
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'(LATENCY)) |-> out_valid == $past(in_valid, 4));

  // R6: reset clears the outputs on the next edge.
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && y_out == '0));

endmodule

// File: tb/shiftadd_fir_tb.sv
module shiftadd_fir_tb;
  localparam int IN_W  = 12;
  localparam int NT    = 8;
  localparam int ACC_W = 23;
  localparam int C [NT] = '{3, -7, 14, 0, -28, 21, 6, -1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_x = '0;
  logic out_valid;
  logic signed [ACC_W-1:0] y_out;

  shiftadd_fir u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .y_out(y_out)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string req = "R1";
  longint hist [NT];
  longint exp_val [$];
  int     exp_cyc [$];
  longint last_y = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string r, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, expv, cyc);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard: compares every result with the convolution model.
  always @(negedge clk) begin
    if (rst) begin
      last_y = 0;
    end else if (out_valid) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R4 unexpected out_valid", 1, 0);
      end else begin
        check(longint'(y_out) == exp_val[0], req, longint'(y_out), exp_val[0]);
        check(cyc == exp_cyc[0], "R4 latency", cyc, exp_cyc[0]);
        void'(exp_val.pop_front());
        void'(exp_cyc.pop_front());
      end
      last_y = longint'(y_out);
    end else begin
      check(longint'(y_out) == last_y, "R5 hold", longint'(y_out), last_y);
    end
  end

  // Watchdog.
  initial begin
    #1500000;
    check(1'b0, "watchdog", cyc, 0);
    report();
  end

  task automatic clear_hist();
    for (int k = 0; k < NT; k++) hist[k] = 0;
  endtask

  task automatic send(input int v);
    longint s;
    @(negedge clk);
    in_valid = 1'b1;
    in_x = IN_W'(v);
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    s = 0;
    for (int k = 0; k < NT; k++) s += longint'(C[k]) * hist[k];
    exp_val.push_back(s);
    exp_cyc.push_back(cyc + 4);
  endtask

  task automatic idle(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_x = junk ? IN_W'($urandom) : '0;
    end
  endtask

  task automatic drain();
    idle(1, 1'b1);
    for (int i = 0; i < 20 && exp_val.size() != 0; i++) idle(1, 1'b1);
    check(exp_val.size() == 0, {req, " drained"}, exp_val.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    idle(3, 1'b0);
    check(!out_valid, "R6 reset out_valid", out_valid, 0);
    check(y_out == '0, "R6 reset y_out", longint'(y_out), 0);
    rst = 1'b0;
    clear_hist();
  endtask

  // R2 / R7: impulse gives the coefficients in order.
  task automatic t_impulse(input int a, input string r);
    req = r;
    send(a);
    for (int i = 0; i < NT; i++) send(0);
    drain();
  endtask

  task automatic t_step();
    req = "R1 step";
    for (int i = 0; i < NT + 3; i++) send(1000);
    for (int i = 0; i < NT; i++) send(0);
    drain();
  endtask

  task automatic t_extremes();
    req = "R3 extremes";
    for (int i = 0; i < NT + 2; i++) send(-2048);
    for (int i = 0; i < NT + 2; i++) send(2047);
    for (int i = 0; i < NT; i++) send((i % 2 == 0) ? -2048 : 2047);
    drain();
  endtask

  task automatic t_back_to_back();
    req = "R8 back-to-back random";
    for (int i = 0; i < 300; i++) send(int'($urandom_range(4095)) - 2048);
    drain();
  endtask

  task automatic t_gaps();
    req = "R5 random with gaps";
    for (int i = 0; i < 300; i++) begin
      send(int'($urandom_range(4095)) - 2048);
      if ($urandom_range(2) == 0) idle(int'($urandom_range(1, 3)), 1'b1);
    end
    drain();
  endtask

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    check(!out_valid, "R6 initial out_valid", out_valid, 0);
    check(y_out == '0, "R6 initial y_out", longint'(y_out), 0);
    rst = 1'b0;
    t_impulse(1, "R2 unit impulse");
    t_impulse(-3, "R7 negative impulse");
    t_step();
    t_extremes();
    t_back_to_back();
    t_gaps();
    send(1500); send(-900); send(77);
    drain();
    do_reset();
    t_impulse(5, "R6 impulse after reset");
    report();
  end

endmodule